// File: doc/BRIEF.md
# Inter-processor FIFO mailbox

The block connects two processors that share one clock. Each processor, side A or side B, sees a window of four 32-bit words, picked by a two-bit word index. Word 0 is the sync word and word 1 is the control word. Word 2 is the send port and word 3 is the receive port. Words written to one side's send port come out of the other side's receive port in the order they were written. There are two independent queues, one for each direction.

Beside the queues there is a byte-wide sync channel. Each side sets an 8-bit value that the peer reads back directly. Either side can ring a doorbell that interrupts side A or side B, and the doorbell only reaches a side that has enabled its sync interrupt. Each side also has a control word with four parts: queue status bits, two queue interrupt enables, a send-queue flush, and a master enable for queue traffic. The control word also holds a sticky error flag. That flag records a push into a full send queue or a pop from an empty receive queue.

Reads are combinational. A read of the receive port returns the head word and removes it at the same clock edge.

Top module: `ipcm_top`

## Requirements
- R1: Bits 15:8 of the sync word (index 0) hold the side's outgoing 8-bit value. Writing them requires byte enable 1. The peer reads that value in bits 7:0 of its own sync word, from the cycle after the write.
- R2: Byte lanes are honoured for the sync word. A write with only byte enable 0 changes nothing, because bits 7:0 are read-only. Bit 31 is the read/write sync interrupt enable, and it is written through byte enable 3.
- R3: A sync-word write with byte enable 3 and bit 30 set pulses side A's interrupt for one cycle, provided A's sync enable is 1. The same write with bit 29 set does the same for side B, provided B's sync enable is 1. It does not matter which side writes.
- R4: Words written to a side's send port (index 2) are read from the peer's receive port (index 3) in first-in first-out order. Each direction holds 16 words.
- R5: In the control word (index 1), bit 0 is send-queue empty and bit 1 is send-queue full. Bit 8 is receive-queue empty and bit 9 is receive-queue full. After reset a side reads 0x0101.
- R6: A send into a full queue is discarded. A receive from an empty queue returns the last word popped and changes nothing. Both set the sticky error flag.
- R7: The error flag, control bit 14, stays set until the side writes 1 to bit 14 with byte enable 1.
- R8: Writing 1 to control bit 3 with byte enable 0 empties the side's send queue. The bit always reads 0.
- R9: While control bit 15 (byte enable 1) is 0, sends and receives on that side have no effect, and they do not set the error flag.
- R10: With control bit 2 set, the side's interrupt pulses once when its send queue becomes empty.
- R11: With control bit 10 set, the side's interrupt pulses once when its receive queue becomes non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 2 | Side A word index |
| a_be | input | 4 | Side A byte enables |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Side A interrupt pulse |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 2 | Side B word index |
| b_be | input | 4 | Side B byte enables |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt pulse |

## Verification
The assertions assume that each side presents at most one strobe per cycle. They also assume that a side never flushes its send queue in the same cycle it pushes into it; with a single access per side, that case cannot occur. The stimulus keeps to this by driving one single-cycle access per task call, then dropping the strobes after the clock edge. Interrupt sources are kept apart in time, so that each pulse the bench counts can come from only one cause.

// File: rtl/ipcm_pkg.sv
package ipcm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SYNC_W = 8;

  typedef enum logic [1:0] {
    REG_SYNC = 2'd0,
    REG_CTRL = 2'd1,
    REG_SEND = 2'd2,
    REG_RECV = 2'd3
  } reg_sel_e;

  localparam int unsigned SYNC_IN_LSB  = 0;
  localparam int unsigned SYNC_OUT_LSB = 8;
  localparam int unsigned SYNC_RING_B  = 29;
  localparam int unsigned SYNC_RING_A  = 30;
  localparam int unsigned SYNC_IE_BIT  = 31;

  localparam int unsigned CT_TX_EMPTY = 0;
  localparam int unsigned CT_TX_FULL  = 1;
  localparam int unsigned CT_TX_IE    = 2;
  localparam int unsigned CT_TX_FLUSH = 3;
  localparam int unsigned CT_RX_EMPTY = 8;
  localparam int unsigned CT_RX_FULL  = 9;
  localparam int unsigned CT_RX_IE    = 10;
  localparam int unsigned CT_ERR      = 14;
  localparam int unsigned CT_EN       = 15;
endpackage

// File: rtl/ipcm_fifo.sv
module ipcm_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  last_q, last_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign rdata   = empty ? last_q : mem[rp_q];

  always_comb begin
    wp_n   = wp_q;
    rp_n   = rp_q;
    cnt_n  = cnt_q;
    last_n = last_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
      if (do_pop) begin
        rp_n   = (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
        last_n = mem[rp_q];
      end
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      wp_q   <= wp_n;
      rp_q   <= rp_n;
      cnt_q  <= cnt_n;
      last_q <= last_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(cnt_q));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  assert_drain_to_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && cnt_q == CW'(1)) |=> empty);
endmodule

// File: rtl/ipcm_side.sv
module ipcm_side
  import ipcm_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned SW = SYNC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [3:0]    be,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [SW-1:0] peer_sync,
  output logic [SW-1:0] own_sync,
  output logic          sync_ie,
  output logic [1:0]    ring,
  input  logic          tx_empty,
  input  logic          tx_full,
  input  logic          rx_empty,
  input  logic          rx_full,
  input  logic [W-1:0]  rx_data,
  output logic          push,
  output logic          pop,
  output logic          flush,
  output logic          fifo_irq
);
  logic [SW-1:0] sync_q, sync_n;
  logic sie_q, sie_n, txie_q, txie_n, rxie_q, rxie_n;
  logic en_q, en_n, err_q, err_n, err_clr, err_set;
  logic txe_q, rxe_q, irq_q, irq_n;
  logic wr_sync, wr_ctrl, wr_send, rd_recv;

  assign wr_sync = wr & (addr == REG_SYNC);
  assign wr_ctrl = wr & (addr == REG_CTRL);
  assign wr_send = wr & (addr == REG_SEND);
  assign rd_recv = rd & (addr == REG_RECV);

  assign push    = wr_send & en_q;
  assign pop     = rd_recv & en_q;
  assign flush   = wr_ctrl & be[0] & wdata[CT_TX_FLUSH];
  assign err_clr = wr_ctrl & be[1] & wdata[CT_ERR];
  assign err_set = (push & tx_full) | (pop & rx_empty);
  assign ring[0] = wr_sync & be[3] & wdata[SYNC_RING_A];
  assign ring[1] = wr_sync & be[3] & wdata[SYNC_RING_B];

  assign own_sync = sync_q;
  assign sync_ie  = sie_q;
  assign fifo_irq = irq_q;

  always_comb begin
    sync_n = sync_q;
    sie_n  = sie_q;
    txie_n = txie_q;
    rxie_n = rxie_q;
    en_n   = en_q;
    if (wr_sync && be[1]) sync_n = wdata[SYNC_OUT_LSB +: SW];
    if (wr_sync && be[3]) sie_n  = wdata[SYNC_IE_BIT];
    if (wr_ctrl && be[0]) txie_n = wdata[CT_TX_IE];
    if (wr_ctrl && be[1]) begin
      rxie_n = wdata[CT_RX_IE];
      en_n   = wdata[CT_EN];
    end
    err_n = err_set | (err_q & ~err_clr);
    irq_n = (txie_q & tx_empty & ~txe_q) | (rxie_q & ~rx_empty & rxe_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      sie_q  <= 1'b0;
      txie_q <= 1'b0;
      rxie_q <= 1'b0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      txe_q  <= 1'b1;
      rxe_q  <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      sync_q <= sync_n;
      sie_q  <= sie_n;
      txie_q <= txie_n;
      rxie_q <= rxie_n;
      en_q   <= en_n;
      err_q  <= err_n;
      txe_q  <= tx_empty;
      rxe_q  <= rx_empty;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_sel_e'(addr))
      REG_SYNC: begin
        rdata[SYNC_IN_LSB +: SW]  = peer_sync;
        rdata[SYNC_OUT_LSB +: SW] = sync_q;
        rdata[SYNC_IE_BIT]        = sie_q;
      end
      REG_CTRL: begin
        rdata[CT_TX_EMPTY] = tx_empty;
        rdata[CT_TX_FULL]  = tx_full;
        rdata[CT_TX_IE]    = txie_q;
        rdata[CT_RX_EMPTY] = rx_empty;
        rdata[CT_RX_FULL]  = rx_full;
        rdata[CT_RX_IE]    = rxie_q;
        rdata[CT_ERR]      = err_q;
        rdata[CT_EN]       = en_q;
      end
      REG_RECV: rdata = rx_data;
      default:  rdata = '0;
    endcase
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

  assert_disabled_no_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !err_q) |=> !err_q);
endmodule

// File: rtl/ipcm_top.sv
module ipcm_top
  import ipcm_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned SW    = SYNC_W,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_wr,
  input  logic         a_rd,
  input  logic [1:0]   a_addr,
  input  logic [3:0]   a_be,
  input  logic [W-1:0] a_wdata,
  output logic [W-1:0] a_rdata,
  output logic         a_irq,
  input  logic         b_wr,
  input  logic         b_rd,
  input  logic [1:0]   b_addr,
  input  logic [3:0]   b_be,
  input  logic [W-1:0] b_wdata,
  output logic [W-1:0] b_rdata,
  output logic         b_irq
);
  localparam int unsigned NS = 2;

  logic          s_wr [NS];
  logic          s_rd [NS];
  logic [1:0]    s_addr [NS];
  logic [3:0]    s_be [NS];
  logic [W-1:0]  s_wdata [NS];
  logic [W-1:0]  s_rdata [NS];
  logic [SW-1:0] s_sync [NS];
  logic          s_sie [NS];
  logic [1:0]    s_ring [NS];
  logic          s_push [NS];
  logic          s_pop [NS];
  logic          s_flush [NS];
  logic          s_firq [NS];
  logic [W-1:0]  q_rdata [NS];
  logic          q_empty [NS];
  logic          q_full [NS];
  logic [NS-1:0] bell_q, bell_n;

  assign s_wr[0] = a_wr;   assign s_wr[1] = b_wr;
  assign s_rd[0] = a_rd;   assign s_rd[1] = b_rd;
  assign s_addr[0] = a_addr; assign s_addr[1] = b_addr;
  assign s_be[0] = a_be;   assign s_be[1] = b_be;
  assign s_wdata[0] = a_wdata; assign s_wdata[1] = b_wdata;
  assign a_rdata = s_rdata[0];
  assign b_rdata = s_rdata[1];
  assign a_irq = s_firq[0] | bell_q[0];
  assign b_irq = s_firq[1] | bell_q[1];

  for (genvar s = 0; s < NS; s++) begin : g_side
    localparam int unsigned P = NS - 1 - s;

    ipcm_fifo #(.W(W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (s_push[s]),
      .pop   (s_pop[P]),
      .flush (s_flush[s]),
      .wdata (s_wdata[s]),
      .rdata (q_rdata[s]),
      .empty (q_empty[s]),
      .full  (q_full[s])
    );

    ipcm_side #(.W(W), .SW(SW)) u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (s_wr[s]),
      .rd        (s_rd[s]),
      .addr      (s_addr[s]),
      .be        (s_be[s]),
      .wdata     (s_wdata[s]),
      .rdata     (s_rdata[s]),
      .peer_sync (s_sync[P]),
      .own_sync  (s_sync[s]),
      .sync_ie   (s_sie[s]),
      .ring      (s_ring[s]),
      .tx_empty  (q_empty[s]),
      .tx_full   (q_full[s]),
      .rx_empty  (q_empty[P]),
      .rx_full   (q_full[P]),
      .rx_data   (q_rdata[P]),
      .push      (s_push[s]),
      .pop       (s_pop[s]),
      .flush     (s_flush[s]),
      .fifo_irq  (s_firq[s])
    );

    assign bell_n[s] = (s_ring[0][s] | s_ring[1][s]) & s_sie[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bell_q <= '0;
    else        bell_q <= bell_n;
  end

  assert_bell_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bell_q[0] |-> $past(s_sie[0]));
endmodule

// File: tb/sim_ipcm_top.sv
module sim_ipcm_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [1:0] a_addr = 0, b_addr = 0;
  logic [3:0] a_be = 0, b_be = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  int checks = 0, fails = 0;
  int irq_a_cnt = 0, irq_b_cnt = 0;
  logic [31:0] q_ab[$];
  logic [31:0] q_ba[$];
  logic [31:0] last_ab = 0, last_ba = 0;
  logic [31:0] rv;
  bit done = 0;

  always #4 clk = ~clk;

  ipcm_top u0 (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_be(a_be), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_be(b_be), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  always @(negedge clk) begin
    if (rst_n && a_irq) irq_a_cnt++;
    if (rst_n && b_irq) irq_b_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input int side, input bit wr, input bit rd, input logic [1:0] addr,
                        input logic [3:0] be, input logic [31:0] wd, output logic [31:0] rd_o);
    @(negedge clk);
    if (side == 0) begin
      a_wr = wr; a_rd = rd; a_addr = addr; a_be = be; a_wdata = wd;
    end else begin
      b_wr = wr; b_rd = rd; b_addr = addr; b_be = be; b_wdata = wd;
    end
    #1 rd_o = (side == 0) ? a_rdata : b_rdata;
    @(posedge clk);
    #1;
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
  endtask

  task automatic wr_reg(input int side, input logic [1:0] addr, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] d;
    access(side, 1, 0, addr, be, wd, d);
  endtask

  task automatic rd_reg(input int side, input logic [1:0] addr, output logic [31:0] d);
    access(side, 0, 1, addr, 4'hF, 32'h0, d);
  endtask

  // driver: push the expected word into the scoreboard when the model accepts it
  task automatic send(input int side, input logic [31:0] d, input bit accepted);
    wr_reg(side, 2'd2, 4'hF, d);
    if (accepted) begin
      if (side == 0) q_ab.push_back(d);
      else           q_ba.push_back(d);
    end
  endtask

  // monitor: pop the scoreboard and compare with the word the design returns
  task automatic recv(input int side, input string req);
    logic [31:0] d, e;
    rd_reg(side, 2'd3, d);
    if (side == 1) begin
      if (q_ab.size() > 0) begin e = q_ab.pop_front(); last_ab = e; end
      else e = last_ab;
    end else begin
      if (q_ba.size() > 0) begin e = q_ba.pop_front(); last_ba = e; end
      else e = last_ba;
    end
    check(req, d, e);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int ia, ib;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R5 reset state
    rd_reg(0, 2'd1, rv); check("R5 reset ctrl A", rv, 32'h0101);
    rd_reg(1, 2'd1, rv); check("R5 reset ctrl B", rv, 32'h0101);
    check("R5 reset irq", {31'b0, a_irq | b_irq}, 32'h0);

    // R1 sync value
    wr_reg(0, 2'd0, 4'b0010, 32'h0000_5A00);
    rd_reg(1, 2'd0, rv); check("R1 peer sync B", rv & 32'hFF, 32'h5A);
    rd_reg(0, 2'd0, rv); check("R1 own sync A", rv, 32'h0000_5A00);
    wr_reg(1, 2'd0, 4'b0010, 32'h0000_C300);
    rd_reg(0, 2'd0, rv); check("R1 peer sync A", rv, 32'h0000_5AC3);
    // R2 byte lanes
    wr_reg(0, 2'd0, 4'b0001, 32'hFFFF_FFFF);
    rd_reg(0, 2'd0, rv); check("R2 lane0 ignored", rv, 32'h0000_5AC3);
    wr_reg(0, 2'd0, 4'b1000, 32'h8000_0000);
    rd_reg(0, 2'd0, rv); check("R2 sync enable", rv, 32'h8000_5AC3);

    // R3 doorbells
    ia = irq_a_cnt; ib = irq_b_cnt;
    wr_reg(1, 2'd0, 4'b1000, 32'h4000_0000);
    wr_reg(0, 2'd0, 4'b1000, 32'hA000_0000);
    repeat (3) @(posedge clk);
    check("R3 ring A", irq_a_cnt - ia, 1);
    check("R3 ring B disabled", irq_b_cnt - ib, 0);
    wr_reg(1, 2'd0, 4'b1000, 32'h8000_0000);
    ib = irq_b_cnt;
    wr_reg(0, 2'd0, 4'b1000, 32'hA000_0000);
    repeat (3) @(posedge clk);
    check("R3 ring B enabled", irq_b_cnt - ib, 1);

    // R9 disabled queues
    send(0, 32'h0000_1234, 0);
    wr_reg(0, 2'd1, 4'b0010, 32'h8000);
    wr_reg(1, 2'd1, 4'b0010, 32'h8000);
    rd_reg(1, 2'd1, rv); check("R9 disabled send dropped", rv, 32'h8101);
    rd_reg(0, 2'd1, rv); check("R9 no error", rv, 32'h8101);

    // R4 transfers both directions
    for (int i = 0; i < 5; i++) send(0, 32'hA000_0000 + i * 32'h1111, 1);
    for (int i = 0; i < 3; i++) send(1, 32'hB000_0000 + i * 32'h0203, 1);
    for (int i = 0; i < 5; i++) recv(1, "R4 A to B");
    for (int i = 0; i < 3; i++) recv(0, "R4 B to A");

    // R5 full, R6 overflow and underflow
    for (int i = 0; i < 16; i++) send(0, 32'hC000_0000 + i, 1);
    rd_reg(0, 2'd1, rv); check("R5 send full", rv, 32'h8102);
    rd_reg(1, 2'd1, rv); check("R5 recv full", rv, 32'h8201);
    send(0, 32'hDEAD_BEEF, 0);
    rd_reg(0, 2'd1, rv); check("R6 overflow error", rv, 32'hC102);
    for (int i = 0; i < 16; i++) recv(1, "R6 no overwrite");
    recv(1, "R6 empty read last word");
    rd_reg(1, 2'd1, rv); check("R6 underflow error", rv, 32'hC101);

    // R7 sticky and write-one-clear
    wr_reg(1, 2'd1, 4'b0010, 32'h8000);
    rd_reg(1, 2'd1, rv); check("R7 sticky", rv, 32'hC101);
    wr_reg(1, 2'd1, 4'b0010, 32'hC000);
    rd_reg(1, 2'd1, rv); check("R7 cleared", rv, 32'h8101);
    wr_reg(0, 2'd1, 4'b0010, 32'hC000);
    rd_reg(0, 2'd1, rv); check("R7 cleared A", rv, 32'h8101);

    // R8 flush
    for (int i = 0; i < 3; i++) send(0, 32'hE000_0000 + i, 1);
    wr_reg(0, 2'd1, 4'b0011, 32'h8008);
    q_ab.delete();
    rd_reg(1, 2'd1, rv); check("R8 flushed", rv, 32'h8101);
    rd_reg(0, 2'd1, rv); check("R8 flush bit reads 0", rv, 32'h8101);
    send(0, 32'h0000_0077, 1);
    recv(1, "R8 after flush");

    // R10 send empty interrupt
    wr_reg(0, 2'd1, 4'b0011, 32'h8004);
    ia = irq_a_cnt;
    send(0, 32'h1, 1);
    send(0, 32'h2, 1);
    repeat (3) @(posedge clk);
    check("R10 no pulse on fill", irq_a_cnt - ia, 0);
    recv(1, "R10 data");
    recv(1, "R10 data");
    repeat (3) @(posedge clk);
    check("R10 empty pulse", irq_a_cnt - ia, 1);

    // R11 receive not-empty interrupt
    wr_reg(1, 2'd1, 4'b0010, 32'h8400);
    ib = irq_b_cnt;
    send(0, 32'h3, 1);
    send(0, 32'h4, 1);
    repeat (3) @(posedge clk);
    check("R11 nonempty pulse", irq_b_cnt - ib, 1);
    recv(1, "R11 data");
    recv(1, "R11 data");

    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule